// File: doc/BRIEF.md
# Microcoded Datapath ALU and Shifter

This block is the arithmetic stage of a horizontally microcoded datapath. It takes the holding-register value on its A side and whichever register the microword has placed on the B bus on its B side, combines them under a 6-bit function field, and passes the result through a shifter whose output becomes the C-bus value written back to the register file. The whole path is combinational and settles within one datapath cycle.

The function field does not name operations directly. Two selector bits choose among AND, OR, complement of B and an adder. Four further bits condition the operands: each operand can be forced to zero, A can be inverted, and a carry of one can be injected into the adder. Combining these controls yields the increment, decrement, negate, subtract and constant results that microcode needs, so a register can be stepped in a single pass. A negative flag and a zero flag are taken from the ALU result before it reaches the shifter, so microcode can branch on them whatever shift is chosen.

Top module: `dpas_alu_shift`

## Requirements
- R1: Bit positions of `alu_fn` are [5]=F0, [4]=F1, [3]=ENA, [2]=ENB, [1]=INVA, [0]=INC. With {F0,F1} = 00 the result is AND of the conditioned operands, 01 is OR, 10 is the complement of the conditioned B, 11 is the sum.
- R2: When ENA is 0 the A operand is taken as zero; when ENB is 0 the B operand is taken as zero.
- R3: When INVA is 1 the A operand, after enabling, is bit-inverted (so ENA=0 with INVA=1 gives all ones).
- R4: INC adds a carry of one into the sum only; it has no effect on the AND, OR and complement-of-B results.
- R5: The codes 011000=A, 010100=B, 011010=NOT A, 101100=NOT B, 111100=A+B, 111101=A+B+1, 111001=A+1, 110101=B+1, 111111=B-A, 110110=B-1, 111011=-A, 001100=A AND B, 011100=A OR B, 010000=0, 110001=1, 110010=-1 give those results.
- R6: The sum is taken modulo 2^32; a carry out of bit 31 is discarded.
- R7: `neg_flag` equals bit 31 of the ALU result and `zero_flag` is 1 exactly when the ALU result is all zeros, both taken before the shifter and unaffected by `shift_ctl`.
- R8: `shift_ctl` bit 1 selects a logical left shift by 8 (zeros enter bits 7:0), bit 0 selects an arithmetic right shift by 1 (bit 31 copied into bit 30 and kept), and 00 passes the ALU result unchanged to `c_bus`.
- R9: `shift_ctl` = 11 is illegal and is treated as no shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| h_in | input | 32 | A operand from the holding register |
| b_in | input | 32 | B operand from the B bus |
| alu_fn | input | 6 | Function field: F0, F1, ENA, ENB, INVA, INC |
| shift_ctl | input | 2 | Shift select: bit 1 left by 8, bit 0 arithmetic right by 1 |
| c_bus | output | 32 | Shifted result driven onto the C bus |
| neg_flag | output | 1 | Sign bit of the unshifted ALU result |
| zero_flag | output | 1 | High when the unshifted ALU result is zero |

## Verification
Every one of the sixteen named function codes is applied with several operand pairs, including pairs whose bits differ so that AND, OR and pass-through results cannot be confused, and pairs near zero and all ones so that B-1, -A and B-A expose a wrong carry-in or inversion. Separate patterns toggle INC under logic modes to show it is ignored there, and add operands whose sum overflows to show the carry is dropped. The shifter is driven with negative and positive values in all four control settings, which distinguishes a logical from an arithmetic right shift and shows the illegal setting passing data through, while the flags are read under a shift that would change them if they were taken after the shifter.

// File: rtl/dpas_pkg.sv
package dpas_pkg;

   // Logic-unit selector, packed as {F0, F1}
   typedef enum logic [1:0] {
      LU_AND  = 2'b00,
      LU_OR   = 2'b01,
      LU_NOTB = 2'b10,
      LU_SUM  = 2'b11
   } lu_sel_e;

   // Function field layout, MSB first: F0 F1 ENA ENB INVA INC
   typedef struct packed {
      lu_sel_e sel;
      logic    ena;
      logic    enb;
      logic    inva;
      logic    inc;
   } alu_ctl_t;

   // Shift control: bit 1 = left shift, bit 0 = arithmetic right shift
   typedef enum logic [1:0] {
      SH_NONE = 2'b00,
      SH_SRA  = 2'b01,
      SH_SLL  = 2'b10,
      SH_BAD  = 2'b11
   } shf_sel_e;

   localparam int ADD_BEHAV = 0;
   localparam int ADD_RIPPLE = 1;

endpackage

// File: rtl/dpas_opnd.sv
module dpas_opnd #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_raw,
   input  logic [W-1:0] b_raw,
   input  logic         ena,
   input  logic         enb,
   input  logic         inva,
   output logic [W-1:0] a_eff,
   output logic [W-1:0] b_eff
);

   logic [W-1:0] a_gated;

   assign a_gated = ena ? a_raw : '0;
   assign a_eff   = inva ? ~a_gated : a_gated;
   assign b_eff   = enb ? b_raw : '0;

   always_comb begin
      if (!$isunknown({a_raw, ena, inva})) begin
         // R3
         if (!ena && inva) begin
            inv_of_zero_chk: assert (a_eff == '1);
         end
      end
   end

endmodule

// File: rtl/dpas_adder.sv
module dpas_adder #(
   parameter int W     = 32,
   parameter int STYLE = dpas_pkg::ADD_BEHAV
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] sum
);

   generate
      if (STYLE == dpas_pkg::ADD_BEHAV) begin : g_behav
         assign sum = x + y + {{(W-1){1'b0}}, cin};
      end else begin : g_ripple
         logic [W-1:0] cy;
         assign cy[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i] = x[i] ^ y[i] ^ cy[i];
            if (i < W-1) begin : g_cy
               assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dpas_alu.sv
module dpas_alu
   import dpas_pkg::*;
#(
   parameter int W         = 32,
   parameter int ADD_STYLE = ADD_BEHAV
) (
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   input  alu_ctl_t     ctl,
   output logic [W-1:0] res
);

   logic [W-1:0] a_eff;
   logic [W-1:0] b_eff;
   logic [W-1:0] sum;

   dpas_opnd #(.W(W)) u_opnd (
      .a_raw (a_in),
      .b_raw (b_in),
      .ena   (ctl.ena),
      .enb   (ctl.enb),
      .inva  (ctl.inva),
      .a_eff (a_eff),
      .b_eff (b_eff)
   );

   dpas_adder #(.W(W), .STYLE(ADD_STYLE)) u_add (
      .x   (a_eff),
      .y   (b_eff),
      .cin (ctl.inc),
      .sum (sum)
   );

   always_comb begin
      unique case (ctl.sel)
         LU_AND:  res = a_eff & b_eff;
         LU_OR:   res = a_eff | b_eff;
         LU_NOTB: res = ~b_eff;
         default: res = sum;
      endcase
   end

   always_comb begin
      if (!$isunknown({a_in, b_in, ctl})) begin
         // R2
         if (ctl.sel == LU_AND && !ctl.ena && !ctl.enb) begin
            both_off_zero_chk: assert (res == '0);
         end
         // R4
         if (ctl.sel == LU_SUM && !ctl.ena && ctl.enb && !ctl.inva) begin
            b_plus_inc_chk: assert (res == b_in + {{(W-1){1'b0}}, ctl.inc});
         end
      end
   end

endmodule

// File: rtl/dpas_shifter.sv
module dpas_shifter
   import dpas_pkg::*;
#(
   parameter int W       = 32,
   parameter int SHL_AMT = 8,
   parameter int SHR_AMT = 1
) (
   input  logic [W-1:0] din,
   input  shf_sel_e     sel,
   output logic [W-1:0] dout
);

   always_comb begin
      unique case (sel)
         SH_SLL:  dout = din << SHL_AMT;
         SH_SRA:  dout = W'($signed(din) >>> SHR_AMT);
         default: dout = din;
      endcase
   end

   always_comb begin
      if (!$isunknown({din, sel})) begin
         // R8
         if (sel == SH_SLL) begin
            sll_low_zero_chk: assert (dout[SHL_AMT-1:0] == '0);
         end
         // R8
         if (sel == SH_SRA) begin
            sra_sign_keep_chk: assert (dout[W-1] == din[W-1] && dout[W-2] == din[W-1]);
         end
         // R9
         if (sel == SH_BAD) begin
            both_set_pass_chk: assert (dout == din);
         end
      end
   end

endmodule

// File: rtl/dpas_alu_shift.sv
module dpas_alu_shift
   import dpas_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int SHL_AMT   = 8,
   parameter int SHR_AMT   = 1,
   parameter int ADD_STYLE = ADD_BEHAV
) (
   input  logic [WIDTH-1:0] h_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic [5:0]       alu_fn,
   input  logic [1:0]       shift_ctl,
   output logic [WIDTH-1:0] c_bus,
   output logic             neg_flag,
   output logic             zero_flag
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2 || SHL_AMT < 1 || SHL_AMT >= WIDTH || SHR_AMT < 1 || SHR_AMT >= WIDTH) begin : g_bad_shape
         $error("dpas_alu_shift: width or shift amounts out of range");
      end
      if (ADD_STYLE != ADD_BEHAV && ADD_STYLE != ADD_RIPPLE) begin : g_bad_style
         $error("dpas_alu_shift: unknown adder style");
      end
   endgenerate

   alu_ctl_t         ctl;
   shf_sel_e         shf;
   logic [WIDTH-1:0] alu_res;

   assign ctl = alu_ctl_t'(alu_fn);
   assign shf = shf_sel_e'(shift_ctl);

   dpas_alu #(.W(WIDTH), .ADD_STYLE(ADD_STYLE)) u_alu (
      .a_in (h_in),
      .b_in (b_in),
      .ctl  (ctl),
      .res  (alu_res)
   );

   dpas_shifter #(.W(WIDTH), .SHL_AMT(SHL_AMT), .SHR_AMT(SHR_AMT)) u_shf (
      .din  (alu_res),
      .sel  (shf),
      .dout (c_bus)
   );

   assign neg_flag  = alu_res[MSB];
   assign zero_flag = (alu_res == '0);

   always_comb begin
      if (!$isunknown({h_in, b_in, alu_fn, shift_ctl})) begin
         // R7
         if (shf == SH_NONE) begin
            flags_match_bus_chk: assert (neg_flag == c_bus[MSB] && zero_flag == (c_bus == '0));
         end
      end
   end

endmodule

// File: tb/dpas_alu_shift_bench.sv
module dpas_alu_shift_bench;

   logic        clk = 1'b0;
   logic [31:0] h_in = '0;
   logic [31:0] b_in = '0;
   logic [5:0]  alu_fn = '0;
   logic [1:0]  shift_ctl = '0;
   logic [31:0] c_bus;
   logic        neg_flag;
   logic        zero_flag;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   dpas_alu_shift u_dpas_alu_shift (
      .h_in      (h_in),
      .b_in      (b_in),
      .alu_fn    (alu_fn),
      .shift_ctl (shift_ctl),
      .c_bus     (c_bus),
      .neg_flag  (neg_flag),
      .zero_flag (zero_flag)
   );

   localparam logic [5:0] C_A    = 6'b011000;
   localparam logic [5:0] C_B    = 6'b010100;
   localparam logic [5:0] C_NA   = 6'b011010;
   localparam logic [5:0] C_NB   = 6'b101100;
   localparam logic [5:0] C_AB   = 6'b111100;
   localparam logic [5:0] C_AB1  = 6'b111101;
   localparam logic [5:0] C_A1   = 6'b111001;
   localparam logic [5:0] C_B1   = 6'b110101;
   localparam logic [5:0] C_BMA  = 6'b111111;
   localparam logic [5:0] C_BM1  = 6'b110110;
   localparam logic [5:0] C_NEGA = 6'b111011;
   localparam logic [5:0] C_AND  = 6'b001100;
   localparam logic [5:0] C_OR   = 6'b011100;
   localparam logic [5:0] C_ZERO = 6'b010000;
   localparam logic [5:0] C_ONE  = 6'b110001;
   localparam logic [5:0] C_MONE = 6'b110010;

   task automatic apply(input logic [31:0] a, input logic [31:0] b,
                        input logic [5:0] fn, input logic [1:0] sh);
      @(negedge clk);
      h_in = a;
      b_in = b;
      alu_fn = fn;
      shift_ctl = sh;
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] expect_code(input int idx, input logic [31:0] a, input logic [31:0] b);
      case (idx)
         0:  return a;
         1:  return b;
         2:  return ~a;
         3:  return ~b;
         4:  return a + b;
         5:  return a + b + 32'd1;
         6:  return a + 32'd1;
         7:  return b + 32'd1;
         8:  return b - a;
         9:  return b - 32'd1;
         10: return 32'd0 - a;
         11: return a & b;
         12: return a | b;
         13: return 32'd0;
         14: return 32'd1;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic [5:0] code_of(input int idx);
      case (idx)
         0: return C_A;    1: return C_B;    2: return C_NA;   3: return C_NB;
         4: return C_AB;   5: return C_AB1;  6: return C_A1;   7: return C_B1;
         8: return C_BMA;  9: return C_BM1;  10: return C_NEGA; 11: return C_AND;
         12: return C_OR;  13: return C_ZERO; 14: return C_ONE; default: return C_MONE;
      endcase
   endfunction

   task automatic t_reset_state;
      apply(32'h0, 32'h0, 6'b000000, 2'b00);
      chk("R1 idle all-zero code gives zero", c_bus, 32'h0);
      chk("R7 idle zero flag", {31'b0, zero_flag}, 32'h1);
      chk("R7 idle neg flag", {31'b0, neg_flag}, 32'h0);
   endtask

   task automatic t_selectors;
      apply(32'hF0F0_1234, 32'hFF00_5678, 6'b001100, 2'b00);
      chk("R1 F=00 AND", c_bus, 32'hF000_1230);
      apply(32'hF0F0_1234, 32'hFF00_5678, 6'b011100, 2'b00);
      chk("R1 F=01 OR", c_bus, 32'hFFF0_567C);
      apply(32'hF0F0_1234, 32'hFF00_5678, 6'b101100, 2'b00);
      chk("R1 F=10 NOT B", c_bus, 32'h00FF_A987);
      apply(32'hF0F0_1234, 32'hFF00_5678, 6'b111100, 2'b00);
      chk("R1 F=11 SUM", c_bus, 32'hEFF0_68AC);
   endtask

   task automatic t_enables;
      apply(32'h1234_5678, 32'h0000_00FF, 6'b110100, 2'b00);
      chk("R2 ENA low drops A from sum", c_bus, 32'h0000_00FF);
      apply(32'h1234_5678, 32'h0000_00FF, 6'b111000, 2'b00);
      chk("R2 ENB low drops B from sum", c_bus, 32'h1234_5678);
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'b000000, 2'b00);
      chk("R2 both off AND", c_bus, 32'h0);
   endtask

   task automatic t_invert;
      apply(32'h0F0F_0000, 32'h0, 6'b011010, 2'b00);
      chk("R3 INVA with ENA", c_bus, 32'hF0F0_FFFF);
      apply(32'h0F0F_0000, 32'h0, 6'b010010, 2'b00);
      chk("R3 INVA with ENA low gives ones", c_bus, 32'hFFFF_FFFF);
   endtask

   task automatic t_inc_scope;
      apply(32'h00FF_00FF, 32'h0F0F_0F0F, 6'b001101, 2'b00);
      chk("R4 INC ignored in AND", c_bus, 32'h000F_000F);
      apply(32'h00FF_00FF, 32'h0F0F_0F0F, 6'b011101, 2'b00);
      chk("R4 INC ignored in OR", c_bus, 32'h0FFF_0FFF);
      apply(32'h00FF_00FF, 32'h0F0F_0F0F, 6'b101101, 2'b00);
      chk("R4 INC ignored in NOT B", c_bus, 32'hF0F0_F0F0);
      apply(32'h0000_0010, 32'h0000_0020, 6'b111101, 2'b00);
      chk("R4 INC adds one in SUM", c_bus, 32'h0000_0031);
   endtask

   task automatic t_code_table;
      logic [31:0] av [4] = '{32'h0000_0005, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1357_9BDF};
      logic [31:0] bv [4] = '{32'h0000_0003, 32'h0000_0000, 32'h7FFF_FFFF, 32'h2468_ACE0};
      for (int p = 0; p < 4; p++) begin
         for (int k = 0; k < 16; k++) begin
            apply(av[p], bv[p], code_of(k), 2'b00);
            chk($sformatf("R5 code %b pair %0d", code_of(k), p), c_bus, expect_code(k, av[p], bv[p]));
         end
      end
   endtask

   task automatic t_wrap;
      apply(32'hFFFF_FFFF, 32'h0000_0001, C_AB, 2'b00);
      chk("R6 sum wraps to zero", c_bus, 32'h0);
      chk("R6 wrap zero flag", {31'b0, zero_flag}, 32'h1);
      apply(32'h8000_0000, 32'h8000_0000, C_AB1, 2'b00);
      chk("R6 carry out dropped", c_bus, 32'h1);
   endtask

   task automatic t_flags;
      apply(32'h0, 32'h0000_0001, C_B, 2'b01);
      chk("R7 zero flag pre-shift low", {31'b0, zero_flag}, 32'h0);
      chk("R7 bus after SRA is zero", c_bus, 32'h0);
      apply(32'h0, 32'h0100_0000, C_B, 2'b10);
      chk("R7 zero flag not from shifted bus", {31'b0, zero_flag}, 32'h0);
      apply(32'h0, 32'h0080_0000, C_B, 2'b10);
      chk("R7 neg flag pre-shift", {31'b0, neg_flag}, 32'h0);
      chk("R8 SLL moved bit 23 to 31", c_bus, 32'h8000_0000);
      apply(32'h0, 32'h8000_0000, C_B, 2'b01);
      chk("R7 neg flag set", {31'b0, neg_flag}, 32'h1);
   endtask

   task automatic t_shifts;
      apply(32'h0, 32'h8123_4567, C_B, 2'b00);
      chk("R8 no shift", c_bus, 32'h8123_4567);
      apply(32'h0, 32'h8123_4567, C_B, 2'b10);
      chk("R8 left by 8", c_bus, 32'h2345_6700);
      apply(32'h0, 32'h8123_4567, C_B, 2'b01);
      chk("R8 arith right negative", c_bus, 32'hC091_A2B3);
      apply(32'h0, 32'h4123_4567, C_B, 2'b01);
      chk("R8 arith right positive", c_bus, 32'h2091_A2B3);
   endtask

   task automatic t_both_shift;
      apply(32'h0, 32'h8123_4567, C_B, 2'b11);
      chk("R9 both bits set passes", c_bus, 32'h8123_4567);
      apply(32'h0000_0001, 32'hFFFF_FFFF, C_AB, 2'b11);
      chk("R9 both bits set after sum", c_bus, 32'h0);
   endtask

   initial begin
      t_reset_state();
      t_selectors();
      t_enables();
      t_invert();
      t_inc_scope();
      t_code_table();
      t_wrap();
      t_flags();
      t_shifts();
      t_both_shift();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int n = 0; n < 20000; n++) begin
         @(posedge clk);
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule